// File: doc/BRIEF.md
# ULPI Link Receive Event Tracker

This block sits on the link side of a ULPI connection and watches the three inputs the PHY drives towards the link: the bus-direction line, the next/throttle line and the 8-bit data bus. On every clock it sorts the current cycle into one of four kinds: bus released, turnaround, status byte or packet byte. From that classification it keeps the receive-active state, discards packets the PHY reports as errored, follows the line state, and keeps the host-disconnect flag.

Downstream logic sees received packet bytes with a one-cycle valid strobe, a start marker on the first byte, a separate one-cycle end marker when a packet finishes cleanly, and a one-cycle drop pulse when the PHY reports a receive error. Receive-active can be entered in two ways: the PHY raises direction and next together, or it sends a status byte whose event field reports activity. It is left when the PHY sends a status byte showing no activity, or when it releases the bus, whichever happens first. All outputs are registered and follow the sampled bus cycle by one clock.

Top module: `ulpi_rx_tracker`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every output is 0 and receive-active is clear.
- R2: The first cycle after any change of the direction input is a turnaround cycle. Its data byte is not decoded: it produces no packet byte and does not change the line state.
- R3: A turnaround cycle in which direction rises with next high sets receive-active.
- R4: A status cycle (direction high, next low, not turnaround) whose event field, data bits [5:4], is 01 (active) or 11 (active with error) sets receive-active.
- R5: Receive-active is cleared by the first of two events: a status cycle with event 00 (idle) or 10 (host disconnect), or a cycle with direction low.
- R6: In every status cycle, data bits [1:0] are copied to `line_state`. It holds its value in all other cycles.
- R7: A cycle with direction high, next high and receive-active set, outside turnaround, produces `rx_valid` for one cycle with the byte on `rx_byte`. `rx_sop` is raised with the first such byte of a packet.
- R8: When receive-active clears after at least one byte was delivered and no error was reported, `rx_eop` pulses once, one cycle after the clearing event.
- R9: A status cycle with event 11 pulses `rx_drop` once per packet. The remaining bytes of that packet are suppressed and no `rx_eop` follows.
- R10: `host_disc` is 1 only when host mode is set, both disconnect enables are set, and the latest status byte decoded in host mode carried event 10.
- R11: A cycle with direction and next high outside turnaround while receive-active is clear delivers no byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | ULPI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ulpi_dir | input | 1 | Bus direction from the PHY (1 = PHY drives) |
| ulpi_nxt | input | 1 | Next/throttle from the PHY |
| ulpi_data | input | 8 | Data bus as driven by the PHY |
| host_mode | input | 1 | Both D+ and D- pulldowns enabled |
| disc_rise_en | input | 1 | Rising-edge disconnect report enable |
| disc_fall_en | input | 1 | Falling-edge disconnect report enable |
| rx_byte | output | 8 | Last delivered packet byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |
| rx_sop | output | 1 | First byte of a packet |
| rx_eop | output | 1 | Packet ended cleanly |
| rx_drop | output | 1 | Current packet must be discarded |
| rx_active | output | 1 | Receive-active state |
| line_state | output | 2 | Latest reported line state |
| host_disc | output | 1 | Gated host-disconnect status |

## Verification
The hardest case to reach is a packet that is errored and then stays open, so that further bytes arrive after the drop pulse. The packet must then close through the other ending path, with no end marker. Directed sequences build this case: a packet opened by a status byte, an error status, a byte with next high, and then a closing idle status, and separately an error reported while idle and then a bus release. A pseudo-random phase then mixes direction changes, throttling and all four event codes, and compares every cycle against a behavioural reference.

// File: rtl/ulpi_rx_pkg.sv
package ulpi_rx_pkg;

   typedef enum logic [1:0] {
      EV_IDLE   = 2'b00,
      EV_ACTIVE = 2'b01,
      EV_DISC   = 2'b10,
      EV_ERROR  = 2'b11
   } rx_event_e;

   typedef enum logic [2:0] {
      CYC_RELEASED,
      CYC_TURN,
      CYC_TURN_GO,
      CYC_STATUS,
      CYC_BYTE
   } cyc_kind_e;

endpackage

// File: rtl/ulpi_rx_phase.sv
module ulpi_rx_phase
   import ulpi_rx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      dir_i,
   input  logic      nxt_i,
   output cyc_kind_e kind_o,
   output logic      dir_q_o
);

   logic dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dir_q <= 1'b0;
      else        dir_q <= dir_i;
   end

   always_comb begin
      if (!dir_i)              kind_o = CYC_RELEASED;
      else if (dir_i != dir_q) kind_o = nxt_i ? CYC_TURN_GO : CYC_TURN;
      else                     kind_o = nxt_i ? CYC_BYTE : CYC_STATUS;
   end

   assign dir_q_o = dir_q;

endmodule

// File: rtl/ulpi_rx_status.sv
module ulpi_rx_status
   import ulpi_rx_pkg::*;
#(
   parameter int LS_W      = 2,
   parameter bit DISC_BOTH = 1'b1
)(
   input  logic            clk,
   input  logic            rst_n,
   input  cyc_kind_e       kind_i,
   input  logic [LS_W-1:0] ls_bits_i,
   input  logic [1:0]      ev_bits_i,
   input  logic            host_mode_i,
   input  logic            rise_en_i,
   input  logic            fall_en_i,
   output logic            status_o,
   output rx_event_e       event_o,
   output logic [LS_W-1:0] line_state_o,
   output logic            host_disc_o
);

   logic            disc_q;
   logic            report_en;
   logic [LS_W-1:0] ls_q;

   assign status_o = (kind_i == CYC_STATUS);
   assign event_o  = rx_event_e'(ev_bits_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ls_q   <= '0;
         disc_q <= 1'b0;
      end else if (status_o) begin
         ls_q <= ls_bits_i;
         if (host_mode_i) disc_q <= (event_o == EV_DISC);
      end
   end

   generate
      if (DISC_BOTH) begin : g_both_edges
         assign report_en = rise_en_i & fall_en_i;
      end else begin : g_any_edge
         assign report_en = rise_en_i | fall_en_i;
      end
   endgenerate

   assign line_state_o = ls_q;
   assign host_disc_o  = disc_q & report_en & host_mode_i;

   // R6 / R2: line state only moves on a decoded status cycle
   a_r6_ls_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !status_o |=> $stable(ls_q));

endmodule

// File: rtl/ulpi_rx_framer.sv
module ulpi_rx_framer
   import ulpi_rx_pkg::*;
#(
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  cyc_kind_e         kind_i,
   input  logic              status_i,
   input  rx_event_e         event_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] byte_o,
   output logic              valid_o,
   output logic              sop_o,
   output logic              eop_o,
   output logic              drop_o,
   output logic              active_o
);

   logic active_q, got_q, dropped_q;
   logic open_pkt, close_pkt, err_hit, take;

   always_comb begin
      open_pkt  = !active_q &&
                  ((kind_i == CYC_TURN_GO) ||
                   (status_i && (event_i == EV_ACTIVE || event_i == EV_ERROR)));
      close_pkt = active_q &&
                  ((kind_i == CYC_RELEASED) ||
                   (status_i && (event_i == EV_IDLE || event_i == EV_DISC)));
      err_hit   = status_i && (event_i == EV_ERROR) && !dropped_q;
      take      = (kind_i == CYC_BYTE) && active_q && !dropped_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         got_q     <= 1'b0;
         dropped_q <= 1'b0;
         byte_o    <= '0;
         valid_o   <= 1'b0;
         sop_o     <= 1'b0;
         eop_o     <= 1'b0;
         drop_o    <= 1'b0;
      end else begin
         if (open_pkt)       active_q <= 1'b1;
         else if (close_pkt) active_q <= 1'b0;

         if (open_pkt || close_pkt) got_q <= 1'b0;
         else if (take)             got_q <= 1'b1;

         if (close_pkt)    dropped_q <= 1'b0;
         else if (err_hit) dropped_q <= 1'b1;

         if (take) byte_o <= data_i;
         valid_o <= take;
         sop_o   <= take && !got_q;
         eop_o   <= close_pkt && got_q && !dropped_q;
         drop_o  <= err_hit;
      end
   end

   assign active_o = active_q;

   // R7: a start marker always rides on a delivered byte
   a_r7_sop_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
      sop_o |-> valid_o);
   // R8: end marker only right after receive-active falls
   a_r8_eop_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      eop_o |-> (!active_q && $past(active_q)));
   // R9: drop is a single pulse
   a_r9_drop_single: assert property (@(posedge clk) disable iff (!rst_n)
      drop_o |=> !drop_o);
   // R9: no byte delivered while the packet is marked dropped
   a_r9_no_byte_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      dropped_q |=> !valid_o);

endmodule

// File: rtl/ulpi_rx_tracker.sv
module ulpi_rx_tracker
   import ulpi_rx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int LS_LSB    = 0,
   parameter int LS_W      = 2,
   parameter int EV_LSB    = 4,
   parameter bit DISC_BOTH = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ulpi_dir,
   input  logic              ulpi_nxt,
   input  logic [DATA_W-1:0] ulpi_data,
   input  logic              host_mode,
   input  logic              disc_rise_en,
   input  logic              disc_fall_en,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_valid,
   output logic              rx_sop,
   output logic              rx_eop,
   output logic              rx_drop,
   output logic              rx_active,
   output logic [LS_W-1:0]   line_state,
   output logic              host_disc
);

   localparam int EV_W = 2;
   localparam int LS_MSB = LS_LSB + LS_W - 1;
   localparam int EV_MSB = EV_LSB + EV_W - 1;

   initial begin
      assert (LS_MSB < DATA_W) else $error("line state field outside data bus");
      assert (EV_MSB < DATA_W) else $error("event field outside data bus");
      assert (LS_MSB < EV_LSB || EV_MSB < LS_LSB) else $error("status fields overlap");
   end

   cyc_kind_e kind;
   rx_event_e event_code;
   logic      dir_q, status_cyc;

   ulpi_rx_phase i_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .dir_i   (ulpi_dir),
      .nxt_i   (ulpi_nxt),
      .kind_o  (kind),
      .dir_q_o (dir_q)
   );

   ulpi_rx_status #(.LS_W(LS_W), .DISC_BOTH(DISC_BOTH)) i_status (
      .clk          (clk),
      .rst_n        (rst_n),
      .kind_i       (kind),
      .ls_bits_i    (ulpi_data[LS_MSB:LS_LSB]),
      .ev_bits_i    (ulpi_data[EV_MSB:EV_LSB]),
      .host_mode_i  (host_mode),
      .rise_en_i    (disc_rise_en),
      .fall_en_i    (disc_fall_en),
      .status_o     (status_cyc),
      .event_o      (event_code),
      .line_state_o (line_state),
      .host_disc_o  (host_disc)
   );

   ulpi_rx_framer #(.DATA_W(DATA_W)) i_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind_i   (kind),
      .status_i (status_cyc),
      .event_i  (event_code),
      .data_i   (ulpi_data),
      .byte_o   (rx_byte),
      .valid_o  (rx_valid),
      .sop_o    (rx_sop),
      .eop_o    (rx_eop),
      .drop_o   (rx_drop),
      .active_o (rx_active)
   );

   // R2: a turnaround cycle never yields a byte
   a_r2_turn_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (ulpi_dir != dir_q) |=> !rx_valid);
   // R5: releasing the bus always ends receive-active
   a_r5_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !ulpi_dir |=> !rx_active);
   // R7: delivered bytes only inside receive-active
   a_r7_valid_in_active: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> rx_active);

endmodule

// File: tb/test_ulpi_rx_tracker.sv
`timescale 1ns/1ps
module test_ulpi_rx_tracker;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dir = 1'b0, nxt = 1'b0;
   logic [7:0] data = 8'h00;
   logic       host = 1'b0, re = 1'b0, fe = 1'b0;
   logic [7:0] rx_byte;
   logic       rx_valid, rx_sop, rx_eop, rx_drop, rx_active, host_disc;
   logic [1:0] line_state;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   ulpi_rx_tracker i_ulpi_rx_tracker (
      .clk(clk), .rst_n(rst_n), .ulpi_dir(dir), .ulpi_nxt(nxt), .ulpi_data(data),
      .host_mode(host), .disc_rise_en(re), .disc_fall_en(fe),
      .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop),
      .rx_drop(rx_drop), .rx_active(rx_active), .line_state(line_state),
      .host_disc(host_disc)
   );

   // behavioural reference state
   int m_dirq, m_act, m_got, m_dropped, m_ls, m_disc;
   int m_valid, m_byte, m_sop, m_eop, m_drop;

   task automatic model_reset();
      m_dirq = 0; m_act = 0; m_got = 0; m_dropped = 0; m_ls = 0; m_disc = 0;
      m_valid = 0; m_byte = 0; m_sop = 0; m_eop = 0; m_drop = 0;
   endtask

   task automatic model_step(input int d, input int n, input int x);
      int ev;
      bit ending, opening;
      ending = 0; opening = 0;
      m_valid = 0; m_sop = 0; m_eop = 0; m_drop = 0;
      ev = (x >> 4) & 3;
      if (d == 0) begin
         if (m_act != 0) ending = 1;
      end else if (d != m_dirq) begin
         if (n != 0 && m_act == 0) opening = 1;
      end else if (n == 0) begin
         m_ls = x & 3;
         if (host) m_disc = (ev == 2) ? 1 : 0;
         if ((ev == 0 || ev == 2) && m_act != 0) ending = 1;
         if ((ev == 1 || ev == 3) && m_act == 0) opening = 1;
         if (ev == 3 && m_dropped == 0) begin
            m_drop = 1;
         end
      end else if (m_act != 0 && m_dropped == 0) begin
         m_valid = 1; m_byte = x; m_sop = (m_got == 0) ? 1 : 0; m_got = 1;
      end
      if (ending) begin
         m_eop = (m_got != 0 && m_dropped == 0) ? 1 : 0;
         m_act = 0; m_got = 0; m_dropped = 0;
      end
      if (opening) begin
         m_act = 1; m_got = 0; m_dropped = 0;
      end
      if (m_drop != 0) m_dropped = 1;
      m_dirq = d;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int hd;
      hd = (m_disc != 0 && host && re && fe) ? 1 : 0;
      chk("R7 rx_valid", int'(rx_valid), m_valid);
      if (m_valid != 0) chk("R7 rx_byte", int'(rx_byte), m_byte);
      chk("R7 rx_sop", int'(rx_sop), m_sop);
      chk("R8 rx_eop", int'(rx_eop), m_eop);
      chk("R9 rx_drop", int'(rx_drop), m_drop);
      chk("R5 rx_active", int'(rx_active), m_act);
      chk("R6 line_state", int'(line_state), m_ls);
      chk("R10 host_disc", int'(host_disc), hd);
   endtask

   task automatic step(input logic d, input logic n, input logic [7:0] x);
      @(negedge clk);
      dir = d; nxt = n; data = x;
      @(posedge clk);
      model_step(int'(d), int'(n), int'(x));
      #1;
      compare_all();
   endtask

   initial begin : watchdog
      #1000000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      logic [15:0] lfsr;
      model_reset();
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 rx_active", int'(rx_active), 0);
      chk("R1 rx_valid", int'(rx_valid), 0);
      chk("R1 line_state", int'(line_state), 0);
      chk("R1 host_disc", int'(host_disc), 0);
      rst_n = 1'b1;
      step(0, 0, 8'h00);
      chk("R1 first cycle eop/drop", int'(rx_eop | rx_drop), 0);

      // R2 turnaround data ignored, R6 status decode
      step(1, 0, 8'h03);
      chk("R2 turnaround line_state", int'(line_state), 0);
      step(1, 0, 8'h01);
      chk("R6 line_state", int'(line_state), 1);
      chk("R6 not active", int'(rx_active), 0);
      step(0, 0, 8'h00);

      // R3 start by dir+nxt, bytes, end by release
      step(1, 1, 8'h5A);
      chk("R3 active", int'(rx_active), 1);
      chk("R2 no byte in turnaround", int'(rx_valid), 0);
      step(1, 1, 8'hAA);
      chk("R7 first valid", int'(rx_valid), 1);
      chk("R7 first sop", int'(rx_sop), 1);
      chk("R7 byte", int'(rx_byte), 8'hAA);
      step(1, 1, 8'hBB);
      chk("R7 second sop", int'(rx_sop), 0);
      step(1, 0, 8'h11);
      chk("R6 ls mid packet", int'(line_state), 1);
      chk("R4 still active", int'(rx_active), 1);
      step(1, 1, 8'hDD);
      step(0, 0, 8'h00);
      chk("R5 release clears", int'(rx_active), 0);
      chk("R8 eop after release", int'(rx_eop), 1);
      step(0, 0, 8'h00);
      chk("R8 eop single", int'(rx_eop), 0);

      // R4 start by status byte, R5 end by idle status
      step(1, 0, 8'h00);
      step(1, 0, 8'h12);
      chk("R4 active by status", int'(rx_active), 1);
      step(1, 1, 8'h55);
      chk("R7 sop method two", int'(rx_sop), 1);
      step(1, 0, 8'h02);
      chk("R5 idle status clears", int'(rx_active), 0);
      chk("R8 eop by status", int'(rx_eop), 1);
      step(1, 1, 8'h77);
      chk("R11 idle byte ignored", int'(rx_valid), 0);
      step(0, 0, 8'h00);
      chk("R8 no eop when idle", int'(rx_eop), 0);

      // R9 error inside a packet
      step(1, 0, 8'h00);
      step(1, 0, 8'h11);
      step(1, 1, 8'h01);
      step(1, 0, 8'h31);
      chk("R9 drop pulse", int'(rx_drop), 1);
      step(1, 1, 8'h02);
      chk("R9 byte suppressed", int'(rx_valid), 0);
      chk("R9 drop single", int'(rx_drop), 0);
      step(1, 0, 8'h01);
      step(1, 0, 8'h00);
      chk("R9 no eop", int'(rx_eop), 0);
      chk("R5 cleared", int'(rx_active), 0);
      // R9 error reported while idle
      step(1, 0, 8'h31);
      chk("R9 drop from idle", int'(rx_drop), 1);
      chk("R4 error opens", int'(rx_active), 1);
      step(0, 0, 8'h00);
      chk("R9 no eop release", int'(rx_eop), 0);

      // R10 host disconnect gating
      host = 1; re = 1; fe = 1;
      step(1, 0, 8'h00);
      step(1, 0, 8'h20);
      chk("R10 disc set", int'(host_disc), 1);
      step(1, 0, 8'h00);
      chk("R10 disc cleared", int'(host_disc), 0);
      fe = 0;
      step(1, 0, 8'h20);
      chk("R10 one enable", int'(host_disc), 0);
      fe = 1; host = 0;
      step(1, 0, 8'h20);
      chk("R10 not host", int'(host_disc), 0);
      host = 1;
      step(0, 0, 8'h00);

      // mixed pseudo-random traffic
      lfsr = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
         logic d, n;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         d = (lfsr[3:0] != 4'h0);
         n = lfsr[6] | lfsr[7];
         if (lfsr[11:9] == 3'b000) begin re = lfsr[1]; fe = lfsr[2]; host = lfsr[5]; end
         step(d, n, {lfsr[15:8] ^ lfsr[7:0]});
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule